// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps a 32-bit count of seconds on a simple register bus with APB-style setup and access phases. A prescaler outside the block supplies a one-cycle `tick` strobe. Each strobe advances the count by one, and the count wraps modulo 2^32. Software can overwrite the count by writing the load register. It can also program a match value.

The block latches an alarm status bit whenever the count equals the match value. The count is checked in three cases: on each tick, on a load write, and on a match write. A write that makes the two equal therefore raises the alarm in the same access. A one-bit mask gates the latched status onto the interrupt line. A fixed eight-byte identification sequence can be read from the top of the 4 KiB window.

A small bus state machine follows the transfer phases. Its states are `BUS_IDLE`, `BUS_SETUP` and `BUS_ACCESS`. Its transitions are:
- idle→setup, when `psel` rises without `penable`.
- setup→access, when `penable` joins `psel`.
- access→setup, for a back-to-back transfer.
- access→idle, when `psel` drops.
- setup→idle, on an aborted transfer.

A register write commits only in an access cycle that follows a setup cycle.

Top module: `rtc_alarm_apb`

## Requirements
- R1: Synchronous active-low reset clears the count, match, mask, load-readback and status registers to 0. During reset `irq` is 0.
- R2: A write to offset 0x08 replaces the count with the written data. Each `tick` then adds one, and 0xFFFFFFFF wraps to 0. Offset 0x00 reads the count.
- R3: When a tick makes the count equal to the match value (offset 0x04), the raw status bit is set on that same clock edge.
- R4: A write to offset 0x08 or offset 0x04 also compares the count with the match value. If the count after the write equals the match value after the write, the status is set on that write's edge.
- R5: Once set, the status stays set until software writes offset 0x1C. Any data value clears it, including 0.
- R6: If a status set and a write to 0x1C happen on the same edge, the set wins.
- R7: The mask at offset 0x10 keeps only bit 0 of the written data. `irq` and reads of offset 0x18 both give raw status AND mask. Offset 0x14 reads the raw status alone, in bit 0.
- R8: Offset 0x0C always reads 1, and writes to it change nothing.
- R9: Reads at offsets 0xFE0 through 0xFFC return one byte per word, in bits 7:0. The bytes are 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in address order.
- R10: Reads of offset 0x1C and of unmapped offsets return 0. Writes to offsets 0x00, 0x14, 0x18 and to unmapped offsets change no register.
- R11: A write commits exactly once per transfer, in the access cycle (`psel` and `penable` high) that follows a setup cycle. `prdata` is 0 outside a read access cycle.
- R12: Offset 0x08 reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle seconds strobe from the external prescaler |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the 4 KiB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the read access cycle |
| irq | output | 1 | Alarm interrupt, raw status AND mask |

## Verification
Read data is combinational. It is due in the same access cycle, so the bench samples `prdata` one nanosecond after the falling edge inside that cycle. A write, a tick, or both together take effect on the rising edge that ends the cycle in which they are driven. The bench therefore reads the result back in a later transfer, or samples `irq` after the next falling edge. It never samples at a rising edge. The alarm edge cases (the fourth versus the fifth tick, a tick coinciding with a clear, and wrap-around) each get their own single-edge stimulus, so that an off-by-one in the timing shows up as a wrong value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_MATCH = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_MSKD  = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h01C;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_SETUP  = 2'd1,
        BUS_ACCESS = 2'd2
    } bus_state_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h31;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_stb,
    output logic rd_stb
);
    bus_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   state_d = (psel && !penable) ? BUS_SETUP : BUS_IDLE;
            BUS_SETUP:  state_d = (psel && penable) ? BUS_ACCESS
                                : (psel ? BUS_SETUP : BUS_IDLE);
            BUS_ACCESS: state_d = (psel && !penable) ? BUS_SETUP : BUS_IDLE;
            default:    state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        wr_stb = (state_q == BUS_SETUP) && psel && penable && pwrite;
        rd_stb = (state_q == BUS_SETUP) && psel && penable && !pwrite;
    end

    // R11: one commit per transfer
    p_wr_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    // R11: a commit is preceded by a setup cycle
    p_wr_after_setup_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(psel && !penable));
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_next,
    output logic [W-1:0] load_q
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        if (load_wr)   cnt_next = wdata;
        else if (tick) cnt_next = cnt_q + ONE;
        else           cnt_next = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            load_q <= '0;
        end else begin
            cnt_q <= cnt_next;
            if (load_wr) load_q <= wdata;
        end
    end

    // R2: tick advances by one (with wrap)
    p_tick_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_wr) |=> cnt_q == $past(cnt_q) + ONE);
    // R2: load replaces count
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> cnt_q == $past(wdata));
    // R2: idle count holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_wr,
    input  logic         match_wr,
    input  logic         mask_wr,
    input  logic         clr_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt_next,
    output logic [W-1:0] match_q,
    output logic         mask_q,
    output logic         raw_q
);
    logic [W-1:0] match_next;
    logic         set_cond;

    always_comb begin
        match_next = match_wr ? wdata : match_q;
        set_cond   = (tick || load_wr || match_wr) && (cnt_next == match_next);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            mask_q  <= 1'b0;
            raw_q   <= 1'b0;
        end else begin
            match_q <= match_next;
            if (mask_wr) mask_q <= wdata[0];
            if (set_cond)    raw_q <= 1'b1;
            else if (clr_wr) raw_q <= 1'b0;
        end
    end

    // R5: status holds without a clear
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q && !clr_wr) |=> raw_q);
    // R6: set wins over clear
    p_set_beats_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cond && clr_wr) |=> raw_q);
    // R5: clear without set drops status
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !set_cond) |=> !raw_q);
endmodule

// File: rtl/rtc_alarm_apb.sv
module rtc_alarm_apb
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq
);
    localparam int ID_LO = 5;

    logic wr_stb, rd_stb;
    logic ld_wr, mt_wr, mk_wr, cl_wr;
    logic [DATA_W-1:0] cnt_q, cnt_next, load_q, match_q;
    logic mask_q, raw_q;
    logic id_win;
    logic [DATA_W-1:0] rd_val;

    rtc_bus_fsm u_bus (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .wr_stb(wr_stb), .rd_stb(rd_stb)
    );

    always_comb begin
        ld_wr = wr_stb && (paddr == OFF_LOAD);
        mt_wr = wr_stb && (paddr == OFF_MATCH);
        mk_wr = wr_stb && (paddr == OFF_MASK);
        cl_wr = wr_stb && (paddr == OFF_CLR);
    end

    rtc_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_wr(ld_wr),
        .wdata(pwdata), .cnt_q(cnt_q), .cnt_next(cnt_next), .load_q(load_q)
    );

    rtc_alarm #(.W(DATA_W)) u_alm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_wr(ld_wr),
        .match_wr(mt_wr), .mask_wr(mk_wr), .clr_wr(cl_wr), .wdata(pwdata),
        .cnt_next(cnt_next), .match_q(match_q), .mask_q(mask_q), .raw_q(raw_q)
    );

    always_comb begin
        id_win = (&paddr[ADDR_W-1:ID_LO]) && (paddr[1:0] == 2'b00);
        rd_val = '0;
        if (id_win) begin
            rd_val = {{(DATA_W-8){1'b0}}, id_byte(paddr[4:2])};
        end else begin
            case (paddr)
                OFF_COUNT: rd_val = cnt_q;
                OFF_MATCH: rd_val = match_q;
                OFF_LOAD:  rd_val = load_q;
                OFF_CTRL:  rd_val = {{(DATA_W-1){1'b0}}, 1'b1};
                OFF_MASK:  rd_val = {{(DATA_W-1){1'b0}}, mask_q};
                OFF_RAW:   rd_val = {{(DATA_W-1){1'b0}}, raw_q};
                OFF_MSKD:  rd_val = {{(DATA_W-1){1'b0}}, raw_q & mask_q};
                default:   rd_val = '0;
            endcase
        end
        prdata = rd_stb ? rd_val : '0;
        irq    = raw_q & mask_q;
    end

    // R3: tick reaching match sets status
    p_tick_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_wr && !mt_wr && (cnt_q + DATA_W'(1)) == match_q) |=> raw_q);
    // R7: irq never rises with mask clear
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q |-> !irq);
    // R8: control reads constant 1
    p_ctrl_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && paddr == OFF_CTRL) |-> prdata == 32'd1);
    // R11: bus idle yields zero read data
    p_rd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable) |-> prdata == '0);
endmodule

// File: tb/sim_rtc_alarm_apb.sv
`timescale 1ns/1ps
module sim_rtc_alarm_apb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic irq;
    int n_chk = 0, n_fail = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    rtc_alarm_apb u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] a;
        logic [31:0] d;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h00C, 32'h1,        8'd8},   // R8 control reads 1
        '{1'b1, 12'h008, 32'h100,      8'd2},   // R2 load
        '{1'b0, 12'h000, 32'h100,      8'd2},   // R2 count reads loaded
        '{1'b0, 12'h008, 32'h100,      8'd12},  // R12 load readback
        '{1'b1, 12'h004, 32'h105,      8'd4},   // R4 match write, no equality
        '{1'b0, 12'h004, 32'h105,      8'd4},
        '{1'b0, 12'h014, 32'h0,        8'd4},
        '{1'b1, 12'h010, 32'hFFFFFFFF, 8'd7},   // R7 mask bit 0 only
        '{1'b0, 12'h010, 32'h1,        8'd7},
        '{1'b1, 12'h00C, 32'h0,        8'd8},   // R8 write ignored
        '{1'b0, 12'h00C, 32'h1,        8'd8},
        '{1'b1, 12'h000, 32'h55,       8'd10},  // R10 write to count ignored
        '{1'b1, 12'h040, 32'h77,       8'd10},  // R10 unmapped write ignored
        '{1'b0, 12'h000, 32'h100,      8'd10},
        '{1'b0, 12'h01C, 32'h0,        8'd10},  // R10 clear reads 0
        '{1'b0, 12'hFE0, 32'h31,       8'd9},   // R9 id bytes
        '{1'b0, 12'hFE4, 32'h10,       8'd9},
        '{1'b0, 12'hFE8, 32'h14,       8'd9},
        '{1'b0, 12'hFEC, 32'h00,       8'd9},
        '{1'b0, 12'hFF0, 32'h0D,       8'd9},
        '{1'b0, 12'hFF4, 32'hF0,       8'd9},
        '{1'b0, 12'hFF8, 32'h05,       8'd9},
        '{1'b0, 12'hFFC, 32'hB1,       8'd9},
        '{1'b0, 12'h200, 32'h0,        8'd10}   // R10 unmapped read 0
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1; tick = tk;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; tick = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        bus_rd(12'h000, rv); check("R1 count", rv, 32'h0);
        bus_rd(12'h004, rv); check("R1 match", rv, 32'h0);
        bus_rd(12'h010, rv); check("R1 mask", rv, 32'h0);
        bus_rd(12'h014, rv); check("R1 status", rv, 32'h0);
        check("R11 idle prdata", prdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_wr(VECS[i].a, VECS[i].d, 1'b0);
            else begin
                bus_rd(VECS[i].a, rv);
                check($sformatf("R%0d table %0d", VECS[i].req, i), rv, VECS[i].d);
            end
        end

        // R3: count 0x100, match 0x105
        pulse_tick(4);
        bus_rd(12'h014, rv); check("R3 not yet at 4 ticks", rv, 32'h0);
        pulse_tick(1);
        bus_rd(12'h014, rv); check("R3 set on 5th tick", rv, 32'h1);
        check("R7 irq high", {31'd0, irq}, 32'd1);
        bus_rd(12'h018, rv); check("R7 masked status", rv, 32'h1);
        pulse_tick(1);
        bus_rd(12'h014, rv); check("R5 sticky", rv, 32'h1);
        bus_rd(12'h000, rv); check("R2 count 0x106", rv, 32'h106);
        bus_wr(12'h01C, 32'h0, 1'b0);
        bus_rd(12'h014, rv); check("R5 clear with data 0", rv, 32'h0);
        check("R5 irq low", {31'd0, irq}, 32'd0);

        // R7 mask keeps bit 0 only
        bus_wr(12'h010, 32'h2, 1'b0);
        bus_rd(12'h010, rv); check("R7 mask bit0", rv, 32'h0);

        // R4 load equal to match
        bus_wr(12'h008, 32'h105, 1'b0);
        bus_rd(12'h014, rv); check("R4 load sets", rv, 32'h1);
        check("R7 masked irq", {31'd0, irq}, 32'd0);
        bus_rd(12'h018, rv); check("R7 masked read 0", rv, 32'h0);
        bus_wr(12'h014, 32'h0, 1'b0);
        bus_rd(12'h014, rv); check("R10 write to raw ignored", rv, 32'h1);
        bus_wr(12'h01C, 32'hDEAD, 1'b0);

        // R4 match equal to count
        bus_wr(12'h004, 32'h200, 1'b0);
        bus_wr(12'h008, 32'h1FF, 1'b0);
        bus_rd(12'h014, rv); check("R4 no equality", rv, 32'h0);
        bus_wr(12'h004, 32'h1FF, 1'b0);
        bus_rd(12'h014, rv); check("R4 match write sets", rv, 32'h1);
        bus_wr(12'h01C, 32'h1, 1'b0);

        // R6 tick + clear on same edge
        bus_wr(12'h004, 32'h201, 1'b0);
        bus_wr(12'h008, 32'h200, 1'b0);
        bus_wr(12'h01C, 32'h0, 1'b0);
        bus_rd(12'h014, rv); check("R6 precondition", rv, 32'h0);
        bus_wr(12'h01C, 32'h0, 1'b1);
        bus_rd(12'h014, rv); check("R6 set wins", rv, 32'h1);
        bus_rd(12'h000, rv); check("R6 count", rv, 32'h201);

        // R2 wrap, R12 readback
        bus_wr(12'h008, 32'hFFFFFFFF, 1'b0);
        bus_rd(12'h008, rv); check("R12 readback", rv, 32'hFFFFFFFF);
        pulse_tick(1);
        bus_rd(12'h000, rv); check("R2 wrap", rv, 32'h0);

        // R1 mid-run reset
        bus_wr(12'h010, 32'h1, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        bus_rd(12'h014, rv); check("R1 status after reset", rv, 32'h0);
        bus_rd(12'h008, rv); check("R1 load after reset", rv, 32'h0);
        finish_run();
    end
endmodule